// File: doc/BRIEF.md
# USB PHY Bring-Up and Shutdown Sequencer

This block is a hardware state machine that brings up and shuts down a high-speed chip-to-chip USB PHY without software help. It is the master on a small 32-bit memory-mapped register bus. That bus has an address, write data, read data, one write strobe and one read strobe, and a ready handshake. Each strobe stays asserted until ready comes back. Only one transaction is outstanding at any time.

Four commands drive the block. The init command enables the reference clock, programs the PLL divider word, powers the PLL up and waits for lock. The power-on command enables the PHY, waits for impedance calibration to finish and then waits for a connect event. The power-off and exit commands undo those steps.

Status bits are polled once per millisecond. The millisecond tick comes from a prescaler of the system clock. Each poll stage has its own timeout. The block pulses done for one cycle when a command finishes and holds an error code that names the stage that failed. A failed PLL lock also turns the reference clock off again.

Top module: `usb_phy_seq`

## Requirements
- R1: Init first writes 0x04001AF0 to address 0x1C. This word holds loop-filter select 1 at bit 26, reference divider 0xD at bits 9 and up, and feedback divider 0xF0 at bits 0 and up. It is the first write of the command.
- R2: Init then reads address 0x20 and writes it back with bit 10 (PLL power-up) set and every other bit unchanged.
- R3: refclk_en_o goes high in the cycle after an init command is accepted. Init then re-reads address 0x20 every millisecond tick until bit 15 (lock) is set. It then completes with err_o = 0.
- R4: If lock is not seen within PLL_TMO_MS ticks, init ends with err_o = 1 and refclk_en_o low. The failure comes no earlier than PLL_TMO_MS-1 ticks and no later than PLL_TMO_MS ticks plus a few bus cycles after entry.
- R5: Power-on reads address 0x08 and writes it back in one access with bit 14 cleared and bit 7 set. All other bits are kept.
- R6: Power-on then polls bit 27 of address 0x18 (calibration done). If the bit is not seen within CAL_TMO_MS ticks, the command ends with err_o = 2.
- R7: After calibration, power-on polls bit 1 of address 0x28 (connect event). If the bit is not seen within CONN_TMO_MS ticks, the command ends with err_o = 3. Otherwise it ends with err_o = 0.
- R8: Power-off reads address 0x08 and writes it back with only bit 7 cleared.
- R9: Exit reads address 0x20 and writes it back with only bit 10 cleared. refclk_en_o is low once done is reported.
- R10: A command is accepted only when busy_o is low. A command given while busy_o is high has no effect, and no bus access is made while busy_o is low. Command codes: 0 init, 1 power-on, 2 power-off, 3 exit.
- R11: done_o is high for exactly one cycle per accepted command. err_o holds its value until the next command is accepted.
- R12: rd_o and wr_o are never high together. A strobe, its address and its write data stay stable until ready_i is seen.
- R13: While rst_ni is low, busy_o, done_o, rd_o, wr_o and refclk_en_o are low and err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe, taken only when idle |
| cmd_i | input | 2 | Command: 0 init, 1 power-on, 2 power-off, 3 exit |
| addr_o | output | ADDR_W | Register bus address |
| wdata_o | output | DATA_W | Register bus write data |
| wr_o | output | 1 | Write strobe, held until ready |
| rd_o | output | 1 | Read strobe, held until ready |
| rdata_i | input | DATA_W | Register bus read data, valid with ready |
| ready_i | input | 1 | Transaction completion handshake |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | A command is in progress |
| err_o | output | 2 | 0 ok, 1 PLL lock timeout, 2 calibration timeout, 3 connect timeout |
| refclk_en_o | output | 1 | Reference clock enable |

## Verification
The bench preloads the PHY registers with bits that the sequencer must not touch. A read-modify-write that rebuilt the whole word, or that set and cleared the wrong bits, would wipe out those bits or leave stale ones behind.

Each of the three stages is made to time out on its own. If the error codes were swapped, if the clock enable stayed on after a lock failure, or if a tick counter was off by one, the bench would see the wrong code or a completion outside the expected cycle window.

The lock and calibration bits are made to arrive a few ticks late, which forces several polls before success. A command is given in the middle of a long init. A design that accepted it would make an extra write to the control register.

A reset is asserted in the middle of a command, which shows whether the clock enable and the bus strobes are cleared.

// File: rtl/usb_phy_seq_pkg.sv
package usb_phy_seq_pkg;

  typedef enum logic [1:0] {
    CMD_INIT    = 2'd0,
    CMD_PWR_ON  = 2'd1,
    CMD_PWR_OFF = 2'd2,
    CMD_EXIT    = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_LOCK = 2'd1,
    ERR_CAL  = 2'd2,
    ERR_CONN = 2'd3
  } err_e;

  typedef enum logic [1:0] {
    P_LOCK = 2'd0,
    P_CAL  = 2'd1,
    P_CONN = 2'd2
  } poll_e;

  // register offsets decoded by the PHY
  localparam logic [7:0] A_CTL     = 8'h08;
  localparam logic [7:0] A_CAL     = 8'h18;
  localparam logic [7:0] A_PLL_CFG = 8'h1C;
  localparam logic [7:0] A_PLL_PWR = 8'h20;
  localparam logic [7:0] A_EVT     = 8'h28;

  localparam int B_PHY_EN   = 7;
  localparam int B_SE0_RES  = 14;
  localparam int B_PLL_PU   = 10;
  localparam int B_PLL_LOCK = 15;
  localparam int B_CAL_DONE = 27;
  localparam int B_CONNECT  = 1;

  localparam int F_LPF_SEL = 26;
  localparam int F_REF_DIV = 9;
  localparam int F_FB_DIV  = 0;

  localparam logic [31:0] PLL_CFG_WORD =
      (32'd1 << F_LPF_SEL) | (32'h0D << F_REF_DIV) | (32'hF0 << F_FB_DIV);

endpackage

// File: rtl/usb_phy_seq_tick.sv
module usb_phy_seq_tick #(
  parameter int DIV = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/usb_phy_seq_bus.sv
module usb_phy_seq_bus #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wr_o,
  output logic              rd_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              act_q, we_q, ack_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      we_q    <= 1'b0;
      ack_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      ack_q <= act_q && ready_i;
      if (!act_q && req_i) begin
        act_q   <= 1'b1;
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end else if (act_q && ready_i) begin
        act_q   <= 1'b0;
        rdata_q <= rdata_i;
      end
    end
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign wr_o    = act_q && we_q;
  assign rd_o    = act_q && !we_q;
  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/usb_phy_seq_fsm.sv
module usb_phy_seq_fsm
  import usb_phy_seq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int PLL_TMO_MS  = 100,
  parameter int CAL_TMO_MS  = 100,
  parameter int CONN_TMO_MS = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  input  logic              tick_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              done_o,
  output logic              busy_o,
  output logic [1:0]        err_o,
  output logic              refclk_en_o
);
  localparam int MAX_A  = (PLL_TMO_MS > CAL_TMO_MS) ? PLL_TMO_MS : CAL_TMO_MS;
  localparam int MAX_T  = (MAX_A > CONN_TMO_MS) ? MAX_A : CONN_TMO_MS;
  localparam int MS_W   = $clog2(MAX_T + 1);
  localparam logic [DATA_W-1:0] M_PU   = DATA_W'(1) << B_PLL_PU;
  localparam logic [DATA_W-1:0] M_EN   = DATA_W'(1) << B_PHY_EN;
  localparam logic [DATA_W-1:0] M_SE0  = DATA_W'(1) << B_SE0_RES;

  typedef enum logic [3:0] {
    S_IDLE, S_PLL_CFG, S_PU_RD, S_PU_WR, S_CTL_RD, S_CTL_WR,
    S_POLL_RD, S_POLL_WAIT, S_OFF_RD, S_OFF_WR, S_EXIT_RD, S_EXIT_WR, S_DONE
  } state_e;

  state_e          state_q;
  poll_e           poll_q;
  err_e            err_q;
  logic            issued_q, clk_en_q;
  logic [MS_W-1:0] ms_q, tmo_lim;
  logic [ADDR_W-1:0] poll_addr;
  logic [DATA_W-1:0] poll_mask;
  logic            access_st, in_poll, tmo_hit, bit_seen;
  err_e            fail_code;

  always_comb begin
    unique case (poll_q)
      P_LOCK:  begin tmo_lim = MS_W'(PLL_TMO_MS);  poll_addr = ADDR_W'(A_PLL_PWR);
                     poll_mask = DATA_W'(1) << B_PLL_LOCK; fail_code = ERR_LOCK; end
      P_CAL:   begin tmo_lim = MS_W'(CAL_TMO_MS);  poll_addr = ADDR_W'(A_CAL);
                     poll_mask = DATA_W'(1) << B_CAL_DONE; fail_code = ERR_CAL;  end
      default: begin tmo_lim = MS_W'(CONN_TMO_MS); poll_addr = ADDR_W'(A_EVT);
                     poll_mask = DATA_W'(1) << B_CONNECT;  fail_code = ERR_CONN; end
    endcase
  end

  assign in_poll  = (state_q == S_POLL_RD) || (state_q == S_POLL_WAIT);
  assign tmo_hit  = (ms_q >= tmo_lim);
  assign bit_seen = ((rdata_i & poll_mask) == poll_mask);

  always_comb begin
    access_st = 1'b1;
    we_o      = 1'b0;
    addr_o    = '0;
    wdata_o   = '0;
    unique case (state_q)
      S_PLL_CFG: begin we_o = 1'b1; addr_o = ADDR_W'(A_PLL_CFG); wdata_o = DATA_W'(PLL_CFG_WORD); end
      S_PU_RD:   addr_o = ADDR_W'(A_PLL_PWR);
      S_PU_WR:   begin we_o = 1'b1; addr_o = ADDR_W'(A_PLL_PWR); wdata_o = rdata_i | M_PU; end
      S_CTL_RD:  addr_o = ADDR_W'(A_CTL);
      S_CTL_WR:  begin we_o = 1'b1; addr_o = ADDR_W'(A_CTL); wdata_o = (rdata_i & ~M_SE0) | M_EN; end
      S_POLL_RD: addr_o = poll_addr;
      S_OFF_RD:  addr_o = ADDR_W'(A_CTL);
      S_OFF_WR:  begin we_o = 1'b1; addr_o = ADDR_W'(A_CTL); wdata_o = rdata_i & ~M_EN; end
      S_EXIT_RD: addr_o = ADDR_W'(A_PLL_PWR);
      S_EXIT_WR: begin we_o = 1'b1; addr_o = ADDR_W'(A_PLL_PWR); wdata_o = rdata_i & ~M_PU; end
      default:   access_st = 1'b0;
    endcase
  end

  assign req_o = access_st && !issued_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      poll_q   <= P_LOCK;
      err_q    <= ERR_NONE;
      issued_q <= 1'b0;
      clk_en_q <= 1'b0;
      ms_q     <= '0;
    end else begin
      if (req_o)      issued_q <= 1'b1;
      else if (ack_i) issued_q <= 1'b0;
      if (tick_i && in_poll && !tmo_hit) ms_q <= ms_q + 1'b1;

      unique case (state_q)
        S_IDLE: if (cmd_valid_i) begin
          err_q <= ERR_NONE;
          unique case (cmd_e'(cmd_i))
            CMD_INIT:    begin clk_en_q <= 1'b1; state_q <= S_PLL_CFG; end
            CMD_PWR_ON:  state_q <= S_CTL_RD;
            CMD_PWR_OFF: state_q <= S_OFF_RD;
            default:     state_q <= S_EXIT_RD;
          endcase
        end
        S_PLL_CFG: if (ack_i) state_q <= S_PU_RD;
        S_PU_RD:   if (ack_i) state_q <= S_PU_WR;
        S_PU_WR:   if (ack_i) begin poll_q <= P_LOCK; ms_q <= '0; state_q <= S_POLL_RD; end
        S_CTL_RD:  if (ack_i) state_q <= S_CTL_WR;
        S_CTL_WR:  if (ack_i) begin poll_q <= P_CAL; ms_q <= '0; state_q <= S_POLL_RD; end
        S_POLL_RD: if (ack_i) begin
          if (!bit_seen)            state_q <= S_POLL_WAIT;
          else if (poll_q == P_CAL) begin poll_q <= P_CONN; ms_q <= '0; end
          else                      state_q <= S_DONE;
        end
        S_POLL_WAIT: begin
          if (tmo_hit) begin
            err_q <= fail_code;
            if (poll_q == P_LOCK) clk_en_q <= 1'b0;
            state_q <= S_DONE;
          end else if (tick_i) begin
            state_q <= S_POLL_RD;
          end
        end
        S_OFF_RD:  if (ack_i) state_q <= S_OFF_WR;
        S_OFF_WR:  if (ack_i) state_q <= S_DONE;
        S_EXIT_RD: if (ack_i) state_q <= S_EXIT_WR;
        S_EXIT_WR: if (ack_i) begin clk_en_q <= 1'b0; state_q <= S_DONE; end
        default:   state_q <= S_IDLE;
      endcase
    end
  end

  assign done_o      = (state_q == S_DONE);
  assign busy_o      = (state_q != S_IDLE);
  assign err_o       = err_q;
  assign refclk_en_o = clk_en_q;
endmodule

// File: rtl/usb_phy_seq.sv
module usb_phy_seq #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int TICK_DIV    = 125000,
  parameter int PLL_TMO_MS  = 100,
  parameter int CAL_TMO_MS  = 100,
  parameter int CONN_TMO_MS = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wr_o,
  output logic              rd_o,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              ready_i,
  output logic              done_o,
  output logic              busy_o,
  output logic [1:0]        err_o,
  output logic              refclk_en_o
);
  logic              tick, req, we, ack;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata, rd_q;

  usb_phy_seq_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  usb_phy_seq_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .we_i    (we),
    .addr_i  (req_addr),
    .wdata_i (req_wdata),
    .ready_i (ready_i),
    .rdata_i (rdata_i),
    .addr_o  (addr_o),
    .wdata_o (wdata_o),
    .wr_o    (wr_o),
    .rd_o    (rd_o),
    .ack_o   (ack),
    .rdata_o (rd_q)
  );

  usb_phy_seq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PLL_TMO_MS(PLL_TMO_MS),
    .CAL_TMO_MS(CAL_TMO_MS), .CONN_TMO_MS(CONN_TMO_MS)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .tick_i      (tick),
    .ack_i       (ack),
    .rdata_i     (rd_q),
    .req_o       (req),
    .we_o        (we),
    .addr_o      (req_addr),
    .wdata_o     (req_wdata),
    .done_o      (done_o),
    .busy_o      (busy_o),
    .err_o       (err_o),
    .refclk_en_o (refclk_en_o)
  );
endmodule

// File: rtl/usb_phy_seq_chk.sv
module usb_phy_seq_chk
  import usb_phy_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] wdata_o,
  input logic              wr_o,
  input logic              rd_o,
  input logic              ready_i,
  input logic              done_o,
  input logic              busy_o,
  input logic [1:0]        err_o,
  input logic              refclk_en_o
);
  p_excl_strobe_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));

  p_hold_bus_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) && !ready_i |=>
      (rd_o == $past(rd_o)) && (wr_o == $past(wr_o)) && $stable(addr_o) && $stable(wdata_o));

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(rd_o || wr_o));

  p_ignore_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o && cmd_valid_i |=> busy_o);

  p_err_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> $stable(err_o) || done_o);

  p_lock_fail_clk_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (err_o == 2'd1) |-> !refclk_en_o);

  p_cfg_word_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o && (addr_o == ADDR_W'(A_PLL_CFG)) |-> (wdata_o == DATA_W'(PLL_CFG_WORD)));
endmodule

bind usb_phy_seq usb_phy_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .addr_o      (addr_o),
  .wdata_o     (wdata_o),
  .wr_o        (wr_o),
  .rd_o        (rd_o),
  .ready_i     (ready_i),
  .done_o      (done_o),
  .busy_o      (busy_o),
  .err_o       (err_o),
  .refclk_en_o (refclk_en_o)
);

// File: tb/sim_usb_phy_seq.sv
module sim_usb_phy_seq;
  localparam int DIV   = 20;
  localparam int T_PLL = 100;
  localparam int T_CAL = 100;
  localparam int T_CON = 200;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd = 2'd0;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata = '0;
  logic        wr, rd, ready = 1'b0;
  logic        done, busy, refclk;
  logic [1:0]  err;

  always #4 clk = ~clk;

  usb_phy_seq #(.TICK_DIV(DIV), .PLL_TMO_MS(T_PLL), .CAL_TMO_MS(T_CAL),
                .CONN_TMO_MS(T_CON)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .addr_o(addr), .wdata_o(wdata), .wr_o(wr), .rd_o(rd), .rdata_i(rdata),
    .ready_i(ready), .done_o(done), .busy_o(busy), .err_o(err), .refclk_en_o(refclk)
  );

  // PHY register model
  logic [31:0] r08 = '0, r18 = '0, r1c = '0, r20 = '0;
  logic        lock_ok = 1'b1, cal_ok = 1'b1, conn_ok = 1'b1;
  int          lock_dly = 3 * DIV, cal_dly = 2 * DIV;
  int          lock_cnt = 0, cal_cnt = 0;
  logic [7:0]  wlog [32];
  int          wcnt = 0, excl_viol = 0;
  int          n_chk = 0, n_bad = 0;

  function automatic logic [31:0] rd_val(input logic [7:0] a);
    logic lk, cd, cn;
    lk = lock_ok && r20[10] && (lock_cnt >= lock_dly);
    cd = cal_ok && r08[7] && (cal_cnt >= cal_dly);
    cn = conn_ok && cd;
    case (a)
      8'h08:   return r08;
      8'h18:   return r18 | (32'(cd) << 27);
      8'h1C:   return r1c;
      8'h20:   return r20 | (32'(lk) << 15);
      8'h28:   return (32'(cn) << 1) | (32'(cn) << 2);
      default: return 32'h0;
    endcase
  endfunction

  always @(negedge clk) begin
    lock_cnt = r20[10] ? lock_cnt + 1 : 0;
    cal_cnt  = r08[7]  ? cal_cnt + 1  : 0;
    if (rd && wr) excl_viol++;
    if ((rd || wr) && !ready) begin
      ready = 1'b1;
      rdata = rd_val(addr);
      if (wr) begin
        case (addr)
          8'h08: r08 = wdata;
          8'h1C: r1c = wdata;
          8'h20: r20 = wdata & ~(32'd1 << 15);
          default: ;
        endcase
        if (wcnt < 32) wlog[wcnt] = addr;
        wcnt++;
      end
    end else begin
      ready = 1'b0;
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] c, output logic [1:0] e,
                         output logic ck, output int cyc);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 1;
    while (!done) begin
      @(negedge clk);
      cyc++;
    end
    e  = err;
    ck = refclk;
    @(negedge clk);
    check("R11 done one cycle", 32'(done), 32'd0);
    check("R11 err held", 32'(err), 32'(e));
  endtask

  // {cmd[1:0], lock_ok, cal_ok, conn_ok, exp_err[1:0], exp_refclk}
  localparam logic [7:0] TBL [10] = '{
    8'b00_111_00_1, 8'b01_111_00_1, 8'b10_111_00_1, 8'b11_111_00_0,
    8'b00_011_01_0, 8'b00_111_00_1, 8'b01_101_10_1, 8'b01_110_11_1,
    8'b01_111_00_1, 8'b11_111_00_0
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [1:0]  e;
    logic        ck;
    int          cyc, w0, lo, hi, t;
    logic [31:0] r08_before;

    repeat (3) @(negedge clk);
    check("R13 busy in reset", 32'(busy), 0);
    check("R13 refclk in reset", 32'(refclk), 0);
    check("R13 strobes in reset", 32'(rd | wr), 0);
    check("R13 done/err in reset", {29'd0, done, err}, 0);
    r08 = 32'h0000_4001;
    r20 = 32'h0000_0003;
    rst_ni = 1'b1;

    // directed register sequence
    run_cmd(2'd0, e, ck, cyc);
    check("R3 init err", 32'(e), 0);
    check("R3 refclk after init", 32'(ck), 1);
    check("R1 cfg word", r1c, 32'h0400_1AF0);
    check("R1 first write addr", 32'(wlog[0]), 32'h1C);
    check("R2 second write addr", 32'(wlog[1]), 32'h20);
    check("R2 pll power rmw", r20, 32'h0000_0403);
    check("R12 init write count", 32'(wcnt), 2);
    check("R3 lock polled several ticks", 32'(cyc >= 2 * DIV), 1);
    run_cmd(2'd1, e, ck, cyc);
    check("R7 power-on err", 32'(e), 0);
    check("R5 ctl rmw", r08, 32'h0000_0081);
    run_cmd(2'd2, e, ck, cyc);
    check("R8 power-off ctl", r08, 32'h0000_0001);
    check("R8 refclk kept", 32'(ck), 1);
    run_cmd(2'd3, e, ck, cyc);
    check("R9 exit pll rmw", r20, 32'h0000_0003);
    check("R9 refclk off", 32'(ck), 0);

    // vector table
    for (int i = 0; i < 10; i++) begin
      lock_ok = TBL[i][5];
      cal_ok  = TBL[i][4];
      conn_ok = TBL[i][3];
      run_cmd(TBL[i][7:6], e, ck, cyc);
      check($sformatf("R6/R7/R4 err code vec %0d", i), 32'(e), 32'(TBL[i][2:1]));
      check($sformatf("R4/R9/R3 refclk vec %0d", i), 32'(ck), 32'(TBL[i][0]));
      if (TBL[i][2:1] != 2'd0) begin
        t  = (TBL[i][2:1] == 2'd3) ? T_CON : ((TBL[i][2:1] == 2'd2) ? T_CAL : T_PLL);
        lo = (t - 1) * DIV;
        hi = t * DIV + 4 * DIV + 40;
        check($sformatf("R4 timeout window vec %0d cyc %0d", i, cyc),
              32'(cyc >= lo && cyc <= hi), 1);
      end
    end
    lock_ok = 1'b1; cal_ok = 1'b1; conn_ok = 1'b1;

    // command while busy is ignored
    lock_dly   = 10 * DIV;
    r08_before = r08;
    w0         = wcnt;
    @(negedge clk); cmd_valid = 1'b1; cmd = 2'd0;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (5) @(negedge clk);
    check("R10 busy during init", 32'(busy), 1);
    check("R3 refclk on during init", 32'(refclk), 1);
    cmd_valid = 1'b1; cmd = 2'd2;
    @(negedge clk); cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    check("R10 init err after ignored cmd", 32'(err), 0);
    @(negedge clk);
    check("R10 busy low after done", 32'(busy), 0);
    check("R10 ctl untouched", r08, r08_before);
    check("R10 only init writes", 32'(wcnt - w0), 2);
    lock_dly = 3 * DIV;

    // reset in the middle of a command
    lock_ok = 1'b0;
    @(negedge clk); cmd_valid = 1'b1; cmd = 2'd0;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (20) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R13 busy after reset", 32'(busy), 0);
    check("R13 refclk after reset", 32'(refclk), 0);
    check("R13 strobes after reset", 32'(rd | wr), 0);
    check("R13 err after reset", 32'(err), 0);
    rst_ni = 1'b1;
    lock_ok = 1'b1;
    run_cmd(2'd0, e, ck, cyc);
    check("R3 init after reset", 32'(e), 0);

    check("R12 exclusive strobes", 32'(excl_viol), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule